// File: doc/BRIEF.md
# Ethernet Reply Builder with Address Swap

This block turns each incoming Ethernet frame into a reply frame on the fly. Frames arrive as 64-bit AXI4-Stream beats, each with a byte-enable mask and an end-of-frame flag. The reply exchanges the two MAC address fields and keeps the ethertype as it is. It adds a fixed constant to each of the first two payload bytes and copies every other byte and mask bit through untouched.

The 14-byte header ends inside the second beat, so the first reply beat can only be formed once two beats have arrived. The block stores the first beat, builds both leading reply beats when the second beat comes in, sends one and keeps the other in a single-beat holding stage. From then on each arriving beat pushes out the one held before it, so the reply trails the request by one beat. After the closing beat the block spends one cycle emptying the holding stage, and it takes no input during that cycle.

Byte n of a frame travels in beat n/8 at data bits [8*(n%8)+7 : 8*(n%8)]. Frames must be at least 16 bytes long, which is two beats.

Top module: `mac_swap_echo`

## Requirements
- R1: Reply beat 0 carries the received source MAC (frame bytes 6..11) in byte lanes 0..5, followed by received destination MAC bytes 0..1 (frame bytes 0..1) in lanes 6..7, with mask 8'hFF and no end flag.
- R2: Reply beat 1 carries received destination MAC bytes 2..5 (frame bytes 2..5) in lanes 0..3, and the ethertype (frame bytes 12..13) unchanged in lanes 4..5.
- R3: Reply frame bytes 14 and 15 (lanes 6 and 7 of beat 1) each equal the received byte plus 8'hAA modulo 256, with no carry from one lane to the other.
- R4: Accepting the first beat of a frame causes no output beat; nothing is presented before the second beat has been accepted.
- R5: With no stalls on either side, reply beat 0 is valid in the cycle after input beat 1 is accepted, and the final reply beat is valid two cycles after the final input beat is accepted.
- R6: Every reply beat from index 2 onward equals the received beat of the same index in data and mask. The last reply beat carries the end flag and the received mask of the last input beat.
- R7: In the cycle after a beat with the end flag is accepted (frames of two or more beats), the input ready is low.
- R8: When the input valid drops in the middle of a frame, no extra or repeated beat is emitted, and the reply is complete and correct once input resumes.
- R9: While the output is valid and the downstream ready is low, the input ready is low and the output beat stays unchanged until it is taken.
- R10: A beat that is both the first beat of a frame and carries the end flag is taken and dropped, with no output, and the next frame is processed normally.
- R11: During reset, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 64 | Received frame data, byte 0 in the low lane |
| s_tkeep | input | 8 | Received byte enables |
| s_tlast | input | 1 | Received end of frame |
| s_tvalid | input | 1 | Received beat valid |
| s_tready | output | 1 | Block can take a beat |
| m_tdata | output | 64 | Reply frame data |
| m_tkeep | output | 8 | Reply byte enables |
| m_tlast | output | 1 | Reply end of frame |
| m_tvalid | output | 1 | Reply beat valid |
| m_tready | input | 1 | Downstream takes the reply beat |

## Verification
Every result has a fixed delay from the input handshake that causes it. The first reply beat comes one cycle after the second input beat is accepted. Each middle beat comes one cycle after the next input beat is accepted. The closing beat comes two cycles after the last input beat is accepted, and the input ready is low in the cycle between. The bench drives inputs on the falling edge and samples shortly after. It tags each handshake with the cycle index it was seen in and compares the cycle indices of output events against those offsets in runs without stalls. Runs with gaps or backpressure check content, beat count and beat stability, not fixed timing.

// File: rtl/mac_swap_echo.sv
module mac_swap_echo #(
  parameter logic [7:0] PAY_INC = 8'hAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] s_tdata,
  input  logic [7:0]  s_tkeep,
  input  logic        s_tlast,
  input  logic        s_tvalid,
  output logic        s_tready,
  output logic [63:0] m_tdata,
  output logic [7:0]  m_tkeep,
  output logic        m_tlast,
  output logic        m_tvalid,
  input  logic        m_tready
);

  localparam int BEAT_W = 64;
  localparam int MASK_W = BEAT_W / 8;

  typedef enum logic [1:0] {ST_HDR0, ST_HDR1, ST_BODY, ST_FLUSH} st_t;

  st_t               st;
  logic [47:0]       dst_q;
  logic [15:0]       src_lo_q;
  logic [BEAT_W-1:0] hold_d;
  logic [MASK_W-1:0] hold_k;
  logic              hold_l;
  logic [BEAT_W-1:0] o_d;
  logic [MASK_W-1:0] o_k;
  logic              o_l, o_v;

  wire out_free = !o_v || m_tready;
  wire acc      = s_tvalid && s_tready;

  assign s_tready = out_free && (st != ST_FLUSH);
  assign m_tdata  = o_d;
  assign m_tkeep  = o_k;
  assign m_tlast  = o_l;
  assign m_tvalid = o_v;

  wire [BEAT_W-1:0] rep0 = {dst_q[15:0], s_tdata[31:0], src_lo_q};
  wire [BEAT_W-1:0] rep1 = {s_tdata[63:56] + PAY_INC, s_tdata[55:48] + PAY_INC,
                            s_tdata[47:32], dst_q[47:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR0;
      dst_q    <= '0;
      src_lo_q <= '0;
      hold_d   <= '0;
      hold_k   <= '0;
      hold_l   <= 1'b0;
      o_d      <= '0;
      o_k      <= '0;
      o_l      <= 1'b0;
      o_v      <= 1'b0;
    end else begin
      if (out_free) o_v <= 1'b0;
      case (st)
        ST_HDR0: if (acc) begin
          dst_q    <= s_tdata[47:0];
          src_lo_q <= s_tdata[63:48];
          if (!s_tlast) st <= ST_HDR1;
        end
        ST_HDR1: if (acc) begin
          o_d    <= rep0;
          o_k    <= '1;
          o_l    <= 1'b0;
          o_v    <= 1'b1;
          hold_d <= rep1;
          hold_k <= s_tkeep;
          hold_l <= s_tlast;
          st     <= s_tlast ? ST_FLUSH : ST_BODY;
        end
        ST_BODY: if (acc) begin
          o_d    <= hold_d;
          o_k    <= hold_k;
          o_l    <= 1'b0;
          o_v    <= 1'b1;
          hold_d <= s_tdata;
          hold_k <= s_tkeep;
          hold_l <= s_tlast;
          st     <= s_tlast ? ST_FLUSH : ST_BODY;
        end
        default: if (out_free) begin
          o_d <= hold_d;
          o_k <= hold_k;
          o_l <= hold_l;
          o_v <= 1'b1;
          st  <= ST_HDR0;
        end
      endcase
    end
  end

  a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR0 && s_tvalid && s_tready) |=> !m_tvalid);

  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast && st != ST_HDR0) |=> !s_tready);

  a_r6_flush_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH && (!m_tvalid || m_tready)) |=> (m_tvalid && m_tlast));

  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

  a_r10_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR0 && s_tvalid && s_tready && s_tlast) |=> (st == ST_HDR0 && !m_tvalid));

endmodule

// File: tb/sim_mac_swap_echo.sv
module sim_mac_swap_echo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] s_tdata = '0;
  logic [7:0]  s_tkeep = '0;
  logic        s_tlast = 1'b0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        m_tlast;
  logic        m_tvalid;
  logic        m_tready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mac_swap_echo u0 (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input int seed, input bit gap, input bit bp,
                           input int p0, input int p1);
    logic [7:0]  b [0:127];
    logic [63:0] iw [0:15];
    logic [63:0] ew [0:15];
    logic [7:0]  ik [0:15];
    logic [63:0] pd;
    int nw, idx, outn, t, acc1, accl, first_out, last_out;
    bit done, pstall;
    string req;
    nw = (len + 7) / 8;
    for (int i = 0; i < 128; i++) b[i] = 8'(seed * 37 + i * 13 + 5);
    if (p0 >= 0) b[14] = 8'(p0);
    if (p1 >= 0) b[15] = 8'(p1);
    for (int w = 0; w < nw; w++) begin
      for (int k = 0; k < 8; k++) iw[w][8*k +: 8] = b[8*w + k];
      ik[w] = (w < nw - 1 || len % 8 == 0) ? 8'hFF : 8'(8'hFF >> (8 - len % 8));
      ew[w] = iw[w];
    end
    ew[0] = {b[1], b[0], b[11], b[10], b[9], b[8], b[7], b[6]};
    ew[1] = {8'(b[15] + 8'hAA), 8'(b[14] + 8'hAA), b[13], b[12], b[5], b[4], b[3], b[2]};
    idx = 0; outn = 0; t = 0; acc1 = -1; accl = -1; first_out = -1; last_out = -1;
    done = 0; pstall = 0; pd = '0;
    while (!done && t < 400) begin
      @(negedge clk);
      s_tvalid = (idx < nw) && !(gap && (t % 3 == 2));
      s_tdata  = iw[(idx < nw) ? idx : 0];
      s_tkeep  = ik[(idx < nw) ? idx : 0];
      s_tlast  = (idx == nw - 1);
      m_tready = !(bp && (t % 3 == 1));
      #1;
      if (pstall) chk(m_tvalid && m_tdata == pd, "R9", "output held under backpressure", m_tdata, pd);
      pstall = m_tvalid && !m_tready;
      pd = m_tdata;
      if (pstall) chk(!s_tready, "R9", "input ready while output blocked", 64'(s_tready), 64'd0);
      if (m_tvalid && first_out < 0) begin
        first_out = t;
        chk(acc1 >= 0, "R4", "output before second beat accepted", 64'(t), 64'(acc1 + 1));
      end
      if (accl >= 0 && t == accl + 1 && nw >= 2)
        chk(!s_tready, "R7", "input ready during flush cycle", 64'(s_tready), 64'd0);
      if (m_tvalid && m_tready) begin
        if (outn < nw) begin
          req = (outn == 0) ? "R1" : (outn == 1) ? "R2_R3" : "R6";
          chk(m_tdata == ew[outn], req, $sformatf("beat %0d data", outn), m_tdata, ew[outn]);
          chk(m_tkeep == ((outn == 0) ? 8'hFF : ik[outn]), (outn == 0) ? "R1" : "R6",
              $sformatf("beat %0d mask", outn), 64'(m_tkeep), 64'((outn == 0) ? 8'hFF : ik[outn]));
          chk(m_tlast == (outn == nw - 1), "R6", $sformatf("beat %0d end flag", outn),
              64'(m_tlast), 64'(outn == nw - 1));
        end
        outn++;
        if (m_tlast) begin last_out = t; done = 1; end
      end
      if (s_tvalid && s_tready) begin
        if (idx == 1) acc1 = t;
        if (idx == nw - 1) accl = t;
        idx++;
      end
      t++;
    end
    chk(outn == nw, "R8", "reply beat count", 64'(outn), 64'(nw));
    if (!gap && !bp) begin
      chk(first_out == acc1 + 1, "R5", "first reply cycle", 64'(first_out), 64'(acc1 + 1));
      chk(last_out == accl + 2, "R5", "last reply cycle", 64'(last_out), 64'(accl + 2));
    end
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk(!m_tvalid, "R11", "output valid in reset", 64'(m_tvalid), 64'd0);
    chk(s_tready, "R11", "input ready in reset", 64'(s_tready), 64'd1);
  endtask

  task automatic test_single_drop();
    @(negedge clk);
    s_tvalid = 1; s_tdata = 64'h0123_4567_89AB_CDEF; s_tkeep = 8'hFF; s_tlast = 1; m_tready = 1;
    #1;
    chk(s_tready, "R10", "single beat accepted", 64'(s_tready), 64'd1);
    @(negedge clk);
    s_tvalid = 0; s_tlast = 0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!m_tvalid, "R10", "output after dropped beat", 64'(m_tvalid), 64'd0);
      @(negedge clk);
    end
    run_frame(24, 9, 0, 0, -1, -1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1;
    run_frame(16, 1, 0, 0, -1, -1);
    run_frame(45, 2, 0, 0, -1, -1);
    run_frame(20, 3, 0, 0, 8'hFF, 8'h60);
    run_frame(64, 4, 1, 0, -1, -1);
    run_frame(37, 5, 0, 1, -1, -1);
    run_frame(50, 6, 1, 1, 8'h56, 8'hFF);
    test_single_drop();
    run_frame(16, 7, 0, 0, -1, -1);
    run_frame(17, 8, 0, 0, -1, -1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule